// File: doc/BRIEF.md
# Power-Management Event and Timer Register Block

This block holds the power-management event status, event enable and control registers plus a free-running 24-bit timer, all reached over a small I/O-style bus. The bus carries a 4-bit byte offset and an access size of byte, word or dword. The timer advances by one on every cycle in which the `tick` input is high. `tick` is a one-cycle enable that the surrounding logic derives from the system clock.

When the timer passes its top value it returns to zero and latches a sticky overflow flag. If the overflow enable was set at that moment, the block raises a level interrupt and clears the whole enable register. This delivers only one interrupt per arming. Software clears the flag by writing a one to it, and that write also drops the interrupt. A control write that sets the sleep-enable bit together with the soft-off sleep type produces a one-cycle shutdown request.

Two small state machines run the block. The read-response machine has two states, BUS_IDLE and BUS_REPLY. A read request moves it to BUS_REPLY, where `rd_valid` is high and `rd_data` holds the result. It stays in BUS_REPLY while back-to-back reads arrive and returns to BUS_IDLE otherwise. The interrupt machine also has two states, IRQ_IDLE and IRQ_LIVE. An enabled overflow moves it to IRQ_LIVE. A write that clears the overflow flag returns it to IRQ_IDLE, unless a new overflow lands in the same cycle.

Top module: `pm1_regblock`

## Requirements
- R1: After reset the status reads 0x0000, the enable reads 0x0000, the control reads 0x0001 (bit 0 is the interrupt-routing enable), the timer reads 0, and `sci_irq` and `shutdown_req` are low.
- R2: `req_size` encodes 0 = byte, 1 = word and 2 = dword. A read returns right-justified data on `rd_data` with `rd_valid` high in the cycle after the request. Reads of unmapped or misaligned locations return 0, and writes to them change nothing.
- R3: Status, enable and control are 16-bit registers at offsets 0, 2 and 4. A byte access at the even offset reaches bits 7:0 and one at the odd offset reaches bits 15:8. A word access at the even offset reaches all 16 bits. Control and enable keep every bit as written, including bit 2 of control.
- R4: A dword read at offset 0 returns the enable in bits 31:16 and the status in bits 15:0. A dword write there loads bits 31:16 into the enable and applies bits 15:0 to the status with write-one-to-clear rules.
- R5: Status bit 0 is the timer-overflow flag. Writing a 1 to it clears it, and writing 0 leaves it unchanged.
- R6: The timer is 24 bits wide and counts up once per `tick`. A dword write at offset 8 loads bits 23:0, and a dword read there returns the count zero-extended to 32 bits. When a load and a tick occur in the same cycle, the result is the loaded value plus one.
- R7: A tick at count 0xFFFFFF gives count 0 and sets status bit 0. This set wins over a clear of that bit written in the same cycle.
- R8: If enable bit 0 is set when the overflow occurs, the whole enable register becomes 0 and `sci_irq` goes high. It stays high until software clears status bit 0.
- R9: An overflow with enable bit 0 clear sets status bit 0 but leaves `sci_irq` low.
- R10: A control write whose lanes include bits 15:8, with bit 13 = 1 and bits 12:10 = 3'b111, drives `shutdown_req` high for exactly one cycle. Any other sleep type, and any low-byte-only write, gives no pulse.
- R11: When the shutdown condition comes from a write to the high byte of control alone, the timer is forced to 0, overriding a tick in the same cycle. A word write that triggers shutdown leaves the timer alone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Timer advance enable, one cycle per count |
| req_valid | input | 1 | Bus access present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 4 | Byte offset |
| req_size | input | 2 | 0 byte, 1 word, 2 dword |
| req_wdata | input | 32 | Write data, right-justified |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 32 | Read data, right-justified |
| sci_irq | output | 1 | Level interrupt on enabled overflow |
| shutdown_req | output | 1 | One-cycle soft-off request |

## Verification
The bench drives the timer to the wrap point. It checks that status bit 0 latches, that the enable clears, and that the interrupt holds through further ticks. A design that wrapped at 32 bits or failed to clear the enable would show a stale count or a readable enable bit. It also checks the same-cycle collisions: a load with a tick (the count would be off by one), a status clear with an overflow (the flag would be lost), and a high-byte shutdown write with a tick (the timer would read 1 instead of 0). Sleep types other than soft-off and low-byte-only control writes must not produce a shutdown pulse, and a misaligned word write must leave every register untouched.

// File: rtl/pm1_pkg.sv
package pm1_pkg;
    typedef enum logic [1:0] {
        ACC_BYTE  = 2'd0,
        ACC_WORD  = 2'd1,
        ACC_DWORD = 2'd2
    } acc_size_e;

    localparam int NREG    = 3;
    localparam int REG_STS = 0;
    localparam int REG_EN  = 1;
    localparam int REG_CTL = 2;

    localparam logic [3:0] OFS_TMR = 4'd8;

    localparam int BIT_TOVF   = 0;
    localparam int BIT_TOVFEN = 0;
    localparam int BIT_SLPEN  = 13;
    localparam int SLPTYP_LO  = 10;
    localparam logic [2:0] SLPTYP_OFF = 3'b111;

    typedef enum logic { BUS_IDLE, BUS_REPLY } bus_state_e;
    typedef enum logic { IRQ_IDLE, IRQ_LIVE  } irq_state_e;
endpackage

// File: rtl/pm1_timer.sv
module pm1_timer #(
    parameter int W = 24
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         clr,
    output logic [W-1:0] count,
    output logic         wrap
);
    localparam logic [W-1:0] TOP = '1;

    logic [W-1:0] count_q;
    logic [W-1:0] base;

    always_comb begin
        base = load ? load_val : count_q;
        wrap = tick && !clr && (base == TOP);
    end

    always_ff @(posedge clk) begin
        if (!rst_n)      count_q <= '0;
        else if (clr)    count_q <= '0;
        else if (tick)   count_q <= base + 1'b1;
        else             count_q <= base;
    end

    assign count = count_q;

    // R7: a wrap event leaves the counter at zero
    p_wrap_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |=> (count == '0));

    // R11: a forced clear leaves the counter at zero
    p_clear_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (count == '0));
endmodule

// File: rtl/pm1_decode.sv
module pm1_decode
    import pm1_pkg::*;
#(
    parameter int AW = 4,
    parameter int DW = 32,
    parameter int RW = 16,
    parameter int TW = 24
) (
    input  logic          req_valid,
    input  logic          req_write,
    input  logic [AW-1:0] req_addr,
    input  logic [1:0]    req_size,
    input  logic [DW-1:0] req_wdata,
    input  logic [RW-1:0] reg_val [NREG],
    input  logic [TW-1:0] tmr_val,
    output logic [1:0]    wr_lane [NREG],
    output logic [RW-1:0] wr_data [NREG],
    output logic          tmr_load,
    output logic [DW-1:0] rd_word
);
    localparam int BW = RW / 2;

    logic wr_en;
    acc_size_e sz;

    assign wr_en = req_valid && req_write;
    assign sz    = acc_size_e'(req_size);

    for (genvar r = 0; r < NREG; r++) begin : g_lane
        localparam logic [AW-1:0] BASE = AW'(2 * r);
        localparam int LOW = (r < 2) ? r * RW : 0;
        always_comb begin
            wr_lane[r] = 2'b00;
            wr_data[r] = '0;
            if (wr_en) begin
                case (sz)
                    ACC_BYTE: begin
                        if (req_addr == BASE) begin
                            wr_lane[r] = 2'b01;
                            wr_data[r] = {{(RW-BW){1'b0}}, req_wdata[BW-1:0]};
                        end else if (req_addr == BASE + 1'b1) begin
                            wr_lane[r] = 2'b10;
                            wr_data[r] = {req_wdata[BW-1:0], {BW{1'b0}}};
                        end
                    end
                    ACC_WORD: begin
                        if (req_addr == BASE) begin
                            wr_lane[r] = 2'b11;
                            wr_data[r] = req_wdata[RW-1:0];
                        end
                    end
                    ACC_DWORD: begin
                        if (r < 2 && req_addr == '0) begin
                            wr_lane[r] = 2'b11;
                            wr_data[r] = req_wdata[LOW +: RW];
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    assign tmr_load = wr_en && (sz == ACC_DWORD) && (req_addr == AW'(OFS_TMR));

    always_comb begin
        rd_word = '0;
        case (sz)
            ACC_BYTE: begin
                for (int r = 0; r < NREG; r++) begin
                    if (req_addr == AW'(2 * r))     rd_word = DW'(reg_val[r][BW-1:0]);
                    if (req_addr == AW'(2 * r + 1)) rd_word = DW'(reg_val[r][RW-1:BW]);
                end
            end
            ACC_WORD: begin
                for (int r = 0; r < NREG; r++) begin
                    if (req_addr == AW'(2 * r)) rd_word = DW'(reg_val[r]);
                end
            end
            ACC_DWORD: begin
                if (req_addr == '0)                rd_word = {reg_val[REG_EN], reg_val[REG_STS]};
                else if (req_addr == AW'(OFS_TMR)) rd_word = DW'(tmr_val);
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/pm1_regblock.sv
module pm1_regblock
    import pm1_pkg::*;
#(
    parameter int          AW      = 4,
    parameter int          TMR_W   = 24,
    parameter logic [15:0] CTL_RST = 16'h0001
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        tick,
    input  logic        req_valid,
    input  logic        req_write,
    input  logic [AW-1:0] req_addr,
    input  logic [1:0]  req_size,
    input  logic [31:0] req_wdata,
    output logic        rd_valid,
    output logic [31:0] rd_data,
    output logic        sci_irq,
    output logic        shutdown_req
);
    localparam int DW = 32;
    localparam int RW = 16;
    localparam int BW = RW / 2;

    logic          sts_ovf;
    logic [RW-1:0] en_q, ctl_q;
    logic [RW-1:0] reg_val [NREG];
    logic [1:0]    wr_lane [NREG];
    logic [RW-1:0] wr_data [NREG];
    logic          tmr_load, tmr_wrap, tmr_clr;
    logic [TMR_W-1:0] tmr_val;
    logic [DW-1:0] rd_word;
    logic          ovf_clr, shut_hit, hi_only, rd_req;
    logic [RW-1:0] en_nxt, ctl_nxt;

    bus_state_e bus_st, bus_nxt;
    irq_state_e irq_st, irq_nxt;

    assign reg_val[REG_STS] = {{(RW-1){1'b0}}, sts_ovf};
    assign reg_val[REG_EN]  = en_q;
    assign reg_val[REG_CTL] = ctl_q;

    pm1_decode #(.AW(AW), .DW(DW), .RW(RW), .TW(TMR_W)) u_decode (
        .req_valid (req_valid),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_size  (req_size),
        .req_wdata (req_wdata),
        .reg_val   (reg_val),
        .tmr_val   (tmr_val),
        .wr_lane   (wr_lane),
        .wr_data   (wr_data),
        .tmr_load  (tmr_load),
        .rd_word   (rd_word)
    );

    pm1_timer #(.W(TMR_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .load     (tmr_load),
        .load_val (req_wdata[TMR_W-1:0]),
        .clr      (tmr_clr),
        .count    (tmr_val),
        .wrap     (tmr_wrap)
    );

    // Write side decode of the control and status lanes
    always_comb begin
        ovf_clr  = wr_lane[REG_STS][0] && wr_data[REG_STS][BIT_TOVF];
        shut_hit = wr_lane[REG_CTL][1] && wr_data[REG_CTL][BIT_SLPEN]
                   && (wr_data[REG_CTL][SLPTYP_LO +: 3] == SLPTYP_OFF);
        hi_only  = (wr_lane[REG_CTL] == 2'b10);
        tmr_clr  = shut_hit && hi_only;
        rd_req   = req_valid && !req_write;

        ctl_nxt = ctl_q;
        if (wr_lane[REG_CTL][0]) ctl_nxt[BW-1:0]  = wr_data[REG_CTL][BW-1:0];
        if (wr_lane[REG_CTL][1]) ctl_nxt[RW-1:BW] = wr_data[REG_CTL][RW-1:BW];

        en_nxt = en_q;
        if (wr_lane[REG_EN][0]) en_nxt[BW-1:0]  = wr_data[REG_EN][BW-1:0];
        if (wr_lane[REG_EN][1]) en_nxt[RW-1:BW] = wr_data[REG_EN][RW-1:BW];
        if (tmr_wrap && en_q[BIT_TOVFEN]) en_nxt = '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sts_ovf      <= 1'b0;
            en_q         <= '0;
            ctl_q        <= CTL_RST;
            shutdown_req <= 1'b0;
        end else begin
            if (tmr_wrap)     sts_ovf <= 1'b1;
            else if (ovf_clr) sts_ovf <= 1'b0;
            en_q         <= en_nxt;
            ctl_q        <= ctl_nxt;
            shutdown_req <= shut_hit;
        end
    end

    // Next-state logic of both machines
    always_comb begin
        bus_nxt = bus_st;
        unique case (bus_st)
            BUS_IDLE:  if (rd_req)  bus_nxt = BUS_REPLY;
            BUS_REPLY: if (!rd_req) bus_nxt = BUS_IDLE;
        endcase

        irq_nxt = irq_st;
        unique case (irq_st)
            IRQ_IDLE: if (tmr_wrap && en_q[BIT_TOVFEN]) irq_nxt = IRQ_LIVE;
            IRQ_LIVE: if (ovf_clr && !tmr_wrap)         irq_nxt = IRQ_IDLE;
        endcase
    end

    // State registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_st  <= BUS_IDLE;
            irq_st  <= IRQ_IDLE;
            rd_data <= '0;
        end else begin
            bus_st <= bus_nxt;
            irq_st <= irq_nxt;
            if (rd_req) rd_data <= rd_word;
        end
    end

    // Outputs derived from the states
    always_comb begin
        rd_valid = (bus_st == BUS_REPLY);
        sci_irq  = (irq_st == IRQ_LIVE);
    end

    // R8: the interrupt only stands while the overflow flag is set
    p_irq_needs_status_r8: assert property (@(posedge clk) disable iff (!rst_n)
        sci_irq |-> sts_ovf);

    // R8: the enable register is empty once the interrupt fires
    p_en_self_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sci_irq) |-> (en_q == '0));

    // R7: an overflow always leaves the flag set
    p_ovf_sets_r7: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_wrap |=> sts_ovf);

    // R11: a high-byte-only shutdown leaves the timer at zero
    p_shut_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (shutdown_req && $past(hi_only)) |-> (tmr_val == '0));

    // R2: read data is valid only after a read request
    p_rd_follow_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(req_valid && !req_write));
endmodule

// File: tb/pm1_regblock_bench.sv
module pm1_regblock_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [3:0]  req_addr = '0;
    logic [1:0]  req_size = '0;
    logic [31:0] req_wdata = '0;
    logic        rd_valid, sci_irq, shutdown_req;
    logic [31:0] rd_data;

    int n_cmp = 0;
    int n_bad = 0;
    logic [31:0] rv;
    logic        sh;

    always #4 clk = ~clk;

    pm1_regblock u_pm1_regblock (
        .clk (clk), .rst_n (rst_n), .tick (tick),
        .req_valid (req_valid), .req_write (req_write), .req_addr (req_addr),
        .req_size (req_size), .req_wdata (req_wdata),
        .rd_valid (rd_valid), .rd_data (rd_data),
        .sci_irq (sci_irq), .shutdown_req (shutdown_req)
    );

    typedef struct packed {
        logic        wr;
        logic [3:0]  addr;
        logic [1:0]  size;
        logic [31:0] wdata;
        logic        chk;
        logic [31:0] exp;
    } vec_t;

    localparam int NV = 20;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 4'd0, 2'd2, 32'h0,        1'b1, 32'h0000_0000}, // R1 status/enable
        '{1'b0, 4'd4, 2'd1, 32'h0,        1'b1, 32'h0000_0001}, // R1 control
        '{1'b0, 4'd8, 2'd2, 32'h0,        1'b1, 32'h0000_0000}, // R1 timer
        '{1'b1, 4'd2, 2'd1, 32'hA5C3,     1'b0, 32'h0},
        '{1'b0, 4'd2, 2'd1, 32'h0,        1'b1, 32'h0000_A5C3}, // R3 word
        '{1'b0, 4'd3, 2'd0, 32'h0,        1'b1, 32'h0000_00A5}, // R3 odd byte
        '{1'b0, 4'd2, 2'd0, 32'h0,        1'b1, 32'h0000_00C3}, // R3 even byte
        '{1'b1, 4'd3, 2'd0, 32'h12,       1'b0, 32'h0},
        '{1'b0, 4'd2, 2'd1, 32'h0,        1'b1, 32'h0000_12C3}, // R3 byte merge
        '{1'b1, 4'd0, 2'd2, 32'h0001_0000, 1'b0, 32'h0},
        '{1'b0, 4'd0, 2'd2, 32'h0,        1'b1, 32'h0001_0000}, // R4 dword pair
        '{1'b1, 4'd4, 2'd0, 32'h04,       1'b0, 32'h0},
        '{1'b1, 4'd5, 2'd0, 32'h20,       1'b0, 32'h0},
        '{1'b0, 4'd4, 2'd1, 32'h0,        1'b1, 32'h0000_2004}, // R3 control bits kept
        '{1'b1, 4'd8, 2'd2, 32'h1234_5678, 1'b0, 32'h0},
        '{1'b0, 4'd8, 2'd2, 32'h0,        1'b1, 32'h0034_5678}, // R6 24-bit load
        '{1'b1, 4'd1, 2'd1, 32'hFFFF,     1'b0, 32'h0},
        '{1'b0, 4'd0, 2'd2, 32'h0,        1'b1, 32'h0001_0000}, // R2 misaligned ignored
        '{1'b0, 4'd6, 2'd1, 32'h0,        1'b1, 32'h0000_0000}, // R2 unmapped
        '{1'b0, 4'd5, 2'd0, 32'h0,        1'b1, 32'h0000_0020}  // R3 high byte read
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic bus(input logic w, input logic [3:0] a, input logic [1:0] s,
                       input logic [31:0] d, input logic tk,
                       output logic [31:0] rd, output logic shut);
        @(negedge clk);
        req_valid = 1'b1; req_write = w; req_addr = a; req_size = s;
        req_wdata = d; tick = tk;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0; tick = 1'b0;
        rd = rd_data; shut = shutdown_req;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); tick = 1'b1;
            @(negedge clk); tick = 1'b0;
        end
    endtask

    task automatic summary;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 irq", {31'b0, sci_irq}, 32'h0);
        check("R1 shutdown", {31'b0, shutdown_req}, 32'h0);
        rst_n = 1'b1;

        for (int v = 0; v < NV; v++) begin
            bus(VECS[v].wr, VECS[v].addr, VECS[v].size, VECS[v].wdata, 1'b0, rv, sh);
            if (VECS[v].chk) begin
                check($sformatf("vector %0d", v), rv, VECS[v].exp);
                if (v == 0) check("R2 rd_valid", {31'b0, rd_valid}, 32'h1);
            end
        end

        // R6 counting and load with tick
        bus(1'b1, 4'd8, 2'd2, 32'h10, 1'b0, rv, sh);
        ticks(3);
        bus(1'b0, 4'd8, 2'd2, 32'h0, 1'b0, rv, sh);
        check("R6 count", rv, 32'h13);
        bus(1'b1, 4'd8, 2'd2, 32'h20, 1'b1, rv, sh);
        bus(1'b0, 4'd8, 2'd2, 32'h0, 1'b0, rv, sh);
        check("R6 load+tick", rv, 32'h21);

        // R7 / R8 enabled overflow
        bus(1'b1, 4'd2, 2'd1, 32'h0001, 1'b0, rv, sh);
        bus(1'b1, 4'd8, 2'd2, 32'hFFFFFE, 1'b0, rv, sh);
        ticks(1);
        bus(1'b0, 4'd8, 2'd2, 32'h0, 1'b0, rv, sh);
        check("R6 top value", rv, 32'hFFFFFF);
        check("R8 irq before wrap", {31'b0, sci_irq}, 32'h0);
        ticks(1);
        bus(1'b0, 4'd8, 2'd2, 32'h0, 1'b0, rv, sh);
        check("R7 wrap to zero", rv, 32'h0);
        bus(1'b0, 4'd0, 2'd1, 32'h0, 1'b0, rv, sh);
        check("R7 status set", rv, 32'h1);
        bus(1'b0, 4'd2, 2'd1, 32'h0, 1'b0, rv, sh);
        check("R8 enable cleared", rv, 32'h0);
        check("R8 irq high", {31'b0, sci_irq}, 32'h1);
        ticks(2);
        check("R8 irq held", {31'b0, sci_irq}, 32'h1);

        // R5 write-one-to-clear
        bus(1'b1, 4'd0, 2'd1, 32'h0000, 1'b0, rv, sh);
        bus(1'b1, 4'd1, 2'd0, 32'hFF, 1'b0, rv, sh);
        bus(1'b0, 4'd0, 2'd1, 32'h0, 1'b0, rv, sh);
        check("R5 zero write keeps", rv, 32'h1);
        check("R8 irq still high", {31'b0, sci_irq}, 32'h1);
        bus(1'b1, 4'd0, 2'd1, 32'h0001, 1'b0, rv, sh);
        bus(1'b0, 4'd0, 2'd1, 32'h0, 1'b0, rv, sh);
        check("R5 one clears", rv, 32'h0);
        check("R8 irq dropped", {31'b0, sci_irq}, 32'h0);

        // R9 overflow without enable, then R4 dword clear
        bus(1'b1, 4'd8, 2'd2, 32'hFFFFFF, 1'b0, rv, sh);
        ticks(1);
        bus(1'b0, 4'd0, 2'd1, 32'h0, 1'b0, rv, sh);
        check("R9 status set", rv, 32'h1);
        check("R9 no irq", {31'b0, sci_irq}, 32'h0);
        bus(1'b1, 4'd0, 2'd2, 32'h0000_0001, 1'b0, rv, sh);
        bus(1'b0, 4'd0, 2'd2, 32'h0, 1'b0, rv, sh);
        check("R4 dword clear", rv, 32'h0);

        // R7 set beats same-cycle clear
        bus(1'b1, 4'd8, 2'd2, 32'hFFFFFF, 1'b0, rv, sh);
        bus(1'b1, 4'd0, 2'd1, 32'h0001, 1'b1, rv, sh);
        bus(1'b0, 4'd0, 2'd1, 32'h0, 1'b0, rv, sh);
        check("R7 set wins", rv, 32'h1);
        bus(1'b1, 4'd0, 2'd1, 32'h0001, 1'b0, rv, sh);

        // R10 / R11 shutdown
        bus(1'b1, 4'd8, 2'd2, 32'h55, 1'b0, rv, sh);
        bus(1'b1, 4'd4, 2'd1, 32'h3C00, 1'b0, rv, sh);
        check("R10 pulse", {31'b0, sh}, 32'h1);
        @(negedge clk);
        check("R10 one cycle", {31'b0, shutdown_req}, 32'h0);
        bus(1'b0, 4'd8, 2'd2, 32'h0, 1'b0, rv, sh);
        check("R11 word keeps timer", rv, 32'h55);
        bus(1'b1, 4'd4, 2'd1, 32'h3800, 1'b0, rv, sh);
        check("R10 type 6 no pulse", {31'b0, sh}, 32'h0);
        bus(1'b1, 4'd4, 2'd0, 32'hFF, 1'b0, rv, sh);
        check("R10 low byte no pulse", {31'b0, sh}, 32'h0);
        bus(1'b1, 4'd8, 2'd2, 32'h77, 1'b0, rv, sh);
        bus(1'b1, 4'd5, 2'd0, 32'h3C, 1'b1, rv, sh);
        check("R10 high byte pulse", {31'b0, sh}, 32'h1);
        bus(1'b0, 4'd8, 2'd2, 32'h0, 1'b0, rv, sh);
        check("R11 timer zeroed", rv, 32'h0);
        bus(1'b0, 4'd4, 2'd1, 32'h0, 1'b0, rv, sh);
        check("R3 control merged", rv, 32'h3CFF);

        // R1 reset again
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        bus(1'b0, 4'd4, 2'd1, 32'h0, 1'b0, rv, sh);
        check("R1 control after reset", rv, 32'h1);
        bus(1'b0, 4'd2, 2'd1, 32'h0, 1'b0, rv, sh);
        check("R1 enable after reset", rv, 32'h0);

        summary();
    end
endmodule